// File: doc/BRIEF.md
# Debug Link Packet Framer

This block sits between a byte-wide UART and the command logic of a debug port. On the receive side it hunts for the sync byte. It then splits the byte stream that follows into a command code, an optional length, a data stream and a trailing checksum. It reports each piece on a registered strobe. At the end of every packet it gives one status pulse, which says whether the checksum matched and whether the code carried the response flag. A packet that stalls in mid-flight for too many byte times is dropped, and the parser goes back to hunting.

The transmit side builds reply packets in the same layout. It accepts a code and a length, forces the response flag into the code, and pulls data bytes from the caller one at a time. It appends the checksum and presents each byte on a valid/ready pair toward the UART. The checksum is the reflected 16-bit frame check sequence: polynomial 0x8408, seed 0xFFFF, final inversion. It covers every byte from the code byte up to the last data byte.

Top module: `dbgpkt_engine`

## Requirements
- R1: While waiting for a packet, every received byte other than 0x55 is ignored and produces no strobe. A received 0x55 starts a packet.
- R2: The byte after sync is the code. If its bit 7 is clear, `cmd_valid` pulses one cycle after the code byte, with `cmd_code` equal to that byte and `cmd_len` equal to 0. The next two bytes are then the checksum.
- R3: If code bit 7 is set, two length bytes follow, most significant first. `cmd_valid` pulses one cycle after the second length byte and carries that length. Then exactly that many data bytes follow. Each data byte appears on `data_byte` with a `data_valid` pulse one cycle after it arrives. A length of 0 goes straight to the checksum.
- R4: The checksum is received low byte first. `pkt_done` pulses one cycle after the second checksum byte. `pkt_crc_ok` is 1 when the received value equals the bit-inverted running CRC, computed with polynomial 0x8408 and seed 0xFFFF over the code, length and data bytes.
- R5: A received checksum of 0x0000 gives `pkt_crc_ok` = 1 whatever the computed value.
- R6: `pkt_code_err` at `pkt_done` equals bit 6 of the packet's code. A code with that bit set is still parsed through to its checksum.
- R7: Inside a packet, more than IDLE_LIMIT `byte_tick` pulses with no byte between them cause a `pkt_abort` pulse one cycle after the expiring tick, and the parser returns to hunting. A byte that arrives in the same cycle as a tick restarts the count. No abort occurs while hunting.
- R8: A `tx_start` seen while idle emits 0x55 and then the code, with bit 6 forced to 1 and bit 7 taken from `tx_code`. If bit 7 is set, the two length bytes follow, most significant first, and then `tx_len` data bytes. Each data byte is taken from `tx_data`, and `tx_data_rd` pulses as it is taken. The packet ends with the checksum, low byte first. A byte is consumed only in a cycle with `tx_out_valid` and `tx_out_ready` both high.
- R9: `tx_start` is ignored while `tx_busy` is high. The packet already in progress is emitted unchanged.
- R10: In any cycle, at most one of `cmd_valid`, `data_valid`, `pkt_done` and `pkt_abort` is high.
- R11: After reset, all strobes, `tx_out_valid` and `tx_busy` are low, and the parser is hunting for sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| byte_tick | input | 1 | One pulse per byte time, drives the idle timeout |
| cmd_valid | output | 1 | Code and length are ready |
| cmd_code | output | 8 | Received code |
| cmd_len | output | 16 | Received length (0 when absent) |
| data_valid | output | 1 | A data byte is present |
| data_byte | output | 8 | Data byte |
| pkt_done | output | 1 | End of packet |
| pkt_crc_ok | output | 1 | Checksum matched or was zero |
| pkt_code_err | output | 1 | Code carried the response flag |
| pkt_abort | output | 1 | Packet dropped on idle timeout |
| tx_start | input | 1 | Begin a reply packet |
| tx_code | input | 8 | Reply code (bit 7 selects length field) |
| tx_len | input | 16 | Reply data length |
| tx_data | input | 8 | Current reply data byte |
| tx_data_rd | output | 1 | `tx_data` consumed this cycle |
| tx_out_valid | output | 1 | Outgoing byte present |
| tx_out_ready | input | 1 | UART accepts the byte |
| tx_out_byte | output | 8 | Outgoing byte |
| tx_busy | output | 1 | Reply packet in progress |

## Verification
The bench sweeps all 256 code values and varies the length with the code. This catches a parser that reads bit 6 instead of bit 7 for the length flag, since the data count or checksum would then shift. It also catches a parser that drops the response-flag error. Checksums are sent correct, corrupted or zero: a design that always trusts the checksum, or that ignores the zero escape, reports the wrong status. The timeout is probed one tick below and exactly at the limit, and with a byte that lands together with a tick. An off-by-one counter aborts early or late, and a counter that misses the restart aborts a live packet. Replies are sent against a ready that stalls every third cycle, with zero and non-zero lengths. Wrong byte order, a skipped stall or a lost flag bit would show up as a mismatched byte.

// File: rtl/dbgpkt_pkg.sv
package dbgpkt_pkg;

    localparam logic [7:0]  SYNC_BYTE     = 8'h55;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_SEED      = 16'hFFFF;
    localparam int          LEN_FLAG_BIT  = 7;
    localparam int          RESP_FLAG_BIT = 6;
    localparam int          LEN_W         = 16;

    typedef enum logic [2:0] {
        RX_HUNT, RX_CODE, RX_LEN_HI, RX_LEN_LO, RX_DATA, RX_CRC_LO, RX_CRC_HI
    } rx_state_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_SYNC, TX_CODE, TX_LEN_HI, TX_LEN_LO, TX_DATA, TX_CRC_LO, TX_CRC_HI
    } tx_state_e;

    typedef struct packed {
        logic [7:0]       code;
        logic [LEN_W-1:0] len;
    } pkt_hdr_t;

    // Advance the reflected CRC by one byte, least significant bit first.
    function automatic logic [15:0] crc_step(input logic [15:0] crc_in, input logic [7:0] b);
        logic [15:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY_REFL;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/dbgpkt_crc_reg.sv
module dbgpkt_crc_reg
    import dbgpkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  byte_in,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clear) crc <= CRC_SEED;
        else if (en)      crc <= crc_step(crc, byte_in);
    end
endmodule

// File: rtl/dbgpkt_idle_timer.sv
module dbgpkt_idle_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic byte_seen,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1) + 1;

    logic [CW-1:0] cnt;

    assign expire = armed && !byte_seen && tick && (cnt == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || !armed || byte_seen) cnt <= '0;
        else if (tick)                  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dbgpkt_rx_parser.sv
module dbgpkt_rx_parser
    import dbgpkt_pkg::*;
#(
    parameter int IDLE_LIMIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             byte_tick,
    output logic             cmd_valid,
    output logic [7:0]       cmd_code,
    output logic [LEN_W-1:0] cmd_len,
    output logic             data_valid,
    output logic [7:0]       data_byte,
    output logic             pkt_done,
    output logic             pkt_crc_ok,
    output logic             pkt_code_err,
    output logic             pkt_abort
);
    rx_state_e        state;
    pkt_hdr_t         hdr;
    logic [LEN_W-1:0] left;
    logic [7:0]       crc_lo_q;
    logic [15:0]      crc_run;
    logic             crc_en;
    logic             expire;
    logic [15:0]      rx_crc;
    logic             crc_match;

    assign crc_en = in_valid && (state == RX_CODE || state == RX_LEN_HI ||
                                 state == RX_LEN_LO || state == RX_DATA);

    dbgpkt_crc_reg crc_i (
        .clk(clk), .rst(rst), .clear(state == RX_HUNT),
        .en(crc_en), .byte_in(in_byte), .crc(crc_run)
    );

    dbgpkt_idle_timer #(.LIMIT(IDLE_LIMIT)) tmr_i (
        .clk(clk), .rst(rst), .armed(state != RX_HUNT),
        .byte_seen(in_valid), .tick(byte_tick), .expire(expire)
    );

    assign rx_crc    = {in_byte, crc_lo_q};
    assign crc_match = (rx_crc == 16'h0000) || (rx_crc == ~crc_run);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= RX_HUNT;
            hdr          <= '0;
            left         <= '0;
            crc_lo_q     <= '0;
            cmd_valid    <= 1'b0;
            cmd_code     <= '0;
            cmd_len      <= '0;
            data_valid   <= 1'b0;
            data_byte    <= '0;
            pkt_done     <= 1'b0;
            pkt_crc_ok   <= 1'b0;
            pkt_code_err <= 1'b0;
            pkt_abort    <= 1'b0;
        end else begin
            cmd_valid  <= 1'b0;
            data_valid <= 1'b0;
            pkt_done   <= 1'b0;
            pkt_abort  <= 1'b0;
            if (expire) begin
                state     <= RX_HUNT;
                pkt_abort <= 1'b1;
            end else if (in_valid) begin
                case (state)
                    RX_HUNT: begin
                        if (in_byte == SYNC_BYTE) state <= RX_CODE;
                    end
                    RX_CODE: begin
                        hdr.code <= in_byte;
                        hdr.len  <= '0;
                        if (in_byte[LEN_FLAG_BIT]) begin
                            state <= RX_LEN_HI;
                        end else begin
                            cmd_valid <= 1'b1;
                            cmd_code  <= in_byte;
                            cmd_len   <= '0;
                            state     <= RX_CRC_LO;
                        end
                    end
                    RX_LEN_HI: begin
                        hdr.len[15:8] <= in_byte;
                        state         <= RX_LEN_LO;
                    end
                    RX_LEN_LO: begin
                        cmd_valid <= 1'b1;
                        cmd_code  <= hdr.code;
                        cmd_len   <= {hdr.len[15:8], in_byte};
                        left      <= {hdr.len[15:8], in_byte};
                        if ({hdr.len[15:8], in_byte} == '0) state <= RX_CRC_LO;
                        else                                state <= RX_DATA;
                    end
                    RX_DATA: begin
                        data_valid <= 1'b1;
                        data_byte  <= in_byte;
                        left       <= left - 1'b1;
                        if (left == LEN_W'(1)) state <= RX_CRC_LO;
                    end
                    RX_CRC_LO: begin
                        crc_lo_q <= in_byte;
                        state    <= RX_CRC_HI;
                    end
                    RX_CRC_HI: begin
                        pkt_done     <= 1'b1;
                        pkt_crc_ok   <= crc_match;
                        pkt_code_err <= hdr.code[RESP_FLAG_BIT];
                        state        <= RX_HUNT;
                    end
                    default: state <= RX_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/dbgpkt_tx_builder.sv
module dbgpkt_tx_builder
    import dbgpkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       code,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       data_in,
    output logic             data_rd,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic             busy
);
    tx_state_e        state;
    pkt_hdr_t         hdr;
    logic [LEN_W-1:0] left;
    logic [15:0]      crc_run;
    logic [15:0]      crc_fin;
    logic             fire;
    logic             crc_en;

    assign busy      = (state != TX_IDLE);
    assign out_valid = busy;
    assign fire      = out_valid && out_ready;
    assign data_rd   = fire && (state == TX_DATA);
    assign crc_en    = fire && (state == TX_CODE || state == TX_LEN_HI ||
                                state == TX_LEN_LO || state == TX_DATA);
    assign crc_fin   = ~crc_run;

    dbgpkt_crc_reg crc_i (
        .clk(clk), .rst(rst), .clear(state == TX_IDLE),
        .en(crc_en), .byte_in(out_byte), .crc(crc_run)
    );

    always_comb begin
        case (state)
            TX_SYNC:   out_byte = SYNC_BYTE;
            TX_CODE:   out_byte = hdr.code;
            TX_LEN_HI: out_byte = hdr.len[15:8];
            TX_LEN_LO: out_byte = hdr.len[7:0];
            TX_DATA:   out_byte = data_in;
            TX_CRC_LO: out_byte = crc_fin[7:0];
            TX_CRC_HI: out_byte = crc_fin[15:8];
            default:   out_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            hdr   <= '0;
            left  <= '0;
        end else if (state == TX_IDLE) begin
            if (start) begin
                hdr.code <= code | (8'h01 << RESP_FLAG_BIT);
                hdr.len  <= len;
                state    <= TX_SYNC;
            end
        end else if (fire) begin
            case (state)
                TX_SYNC:   state <= TX_CODE;
                TX_CODE:   state <= hdr.code[LEN_FLAG_BIT] ? TX_LEN_HI : TX_CRC_LO;
                TX_LEN_HI: state <= TX_LEN_LO;
                TX_LEN_LO: begin
                    left  <= hdr.len;
                    state <= (hdr.len == '0) ? TX_CRC_LO : TX_DATA;
                end
                TX_DATA: begin
                    left <= left - 1'b1;
                    if (left == LEN_W'(1)) state <= TX_CRC_LO;
                end
                TX_CRC_LO: state <= TX_CRC_HI;
                TX_CRC_HI: state <= TX_IDLE;
                default:   state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dbgpkt_engine.sv
module dbgpkt_engine
    import dbgpkt_pkg::*;
#(
    parameter int IDLE_LIMIT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        byte_tick,
    output logic        cmd_valid,
    output logic [7:0]  cmd_code,
    output logic [15:0] cmd_len,
    output logic        data_valid,
    output logic [7:0]  data_byte,
    output logic        pkt_done,
    output logic        pkt_crc_ok,
    output logic        pkt_code_err,
    output logic        pkt_abort,
    input  logic        tx_start,
    input  logic [7:0]  tx_code,
    input  logic [15:0] tx_len,
    input  logic [7:0]  tx_data,
    output logic        tx_data_rd,
    output logic        tx_out_valid,
    input  logic        tx_out_ready,
    output logic [7:0]  tx_out_byte,
    output logic        tx_busy
);
    dbgpkt_rx_parser #(.IDLE_LIMIT(IDLE_LIMIT)) rx_i (
        .clk(clk), .rst(rst),
        .in_valid(rx_valid), .in_byte(rx_byte), .byte_tick(byte_tick),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_len(cmd_len),
        .data_valid(data_valid), .data_byte(data_byte),
        .pkt_done(pkt_done), .pkt_crc_ok(pkt_crc_ok),
        .pkt_code_err(pkt_code_err), .pkt_abort(pkt_abort)
    );

    dbgpkt_tx_builder tx_i (
        .clk(clk), .rst(rst),
        .start(tx_start), .code(tx_code), .len(tx_len),
        .data_in(tx_data), .data_rd(tx_data_rd),
        .out_valid(tx_out_valid), .out_ready(tx_out_ready),
        .out_byte(tx_out_byte), .busy(tx_busy)
    );
endmodule

// File: rtl/dbgpkt_engine_chk.sv
module dbgpkt_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic       cmd_valid,
    input logic [7:0] cmd_code,
    input logic       data_valid,
    input logic       pkt_done,
    input logic       pkt_code_err,
    input logic       pkt_abort,
    input logic       tx_data_rd,
    input logic       tx_out_valid,
    input logic       tx_out_ready,
    input logic [7:0] tx_out_byte
);
    // R10
    rx_event_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid, data_valid, pkt_done, pkt_abort}));

    // R4
    done_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> $past(rx_valid));

    // R3
    data_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> $past(rx_valid));

    // R7
    abort_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_abort |-> !$past(rx_valid));

    // R8
    tx_sync_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_out_valid) |-> (tx_out_byte == 8'h55));

    // R8
    tx_pull_handshake_chk: assert property (@(posedge clk) disable iff (rst)
        tx_data_rd |-> (tx_out_valid && tx_out_ready));

    // R6
    code_err_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && pkt_code_err) |-> cmd_code[6]);
endmodule

bind dbgpkt_engine dbgpkt_engine_chk chk_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .data_valid(data_valid),
    .pkt_done(pkt_done), .pkt_code_err(pkt_code_err), .pkt_abort(pkt_abort),
    .tx_data_rd(tx_data_rd), .tx_out_valid(tx_out_valid),
    .tx_out_ready(tx_out_ready), .tx_out_byte(tx_out_byte)
);

// File: tb/dbgpkt_engine_tb_top.sv
module dbgpkt_engine_tb_top;
    localparam int LIM = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        byte_tick = 1'b0;
    logic        cmd_valid, data_valid, pkt_done, pkt_crc_ok, pkt_code_err, pkt_abort;
    logic [7:0]  cmd_code, data_byte;
    logic [15:0] cmd_len;
    logic        tx_start = 1'b0;
    logic [7:0]  tx_code = 8'h00;
    logic [15:0] tx_len = 16'h0;
    logic [7:0]  tx_data;
    logic        tx_data_rd, tx_out_valid, tx_out_ready, tx_busy;
    logic [7:0]  tx_out_byte;

    always #5 clk = ~clk;

    dbgpkt_engine #(.IDLE_LIMIT(LIM)) dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .byte_tick(byte_tick), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_len(cmd_len), .data_valid(data_valid), .data_byte(data_byte),
        .pkt_done(pkt_done), .pkt_crc_ok(pkt_crc_ok), .pkt_code_err(pkt_code_err),
        .pkt_abort(pkt_abort), .tx_start(tx_start), .tx_code(tx_code),
        .tx_len(tx_len), .tx_data(tx_data), .tx_data_rd(tx_data_rd),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
        .tx_out_byte(tx_out_byte), .tx_busy(tx_busy)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // receive scoreboard
    logic [7:0]  exp_data [64];
    int          cmd_seen, data_cnt, data_bad, done_seen, abort_seen;
    logic [7:0]  got_code;
    logic [15:0] got_len;
    logic        got_ok, got_err;

    // transmit scoreboard
    logic [7:0]  exp_tx [40];
    int          tx_cnt, tx_bad, rd_cnt;
    int          tx_idx;
    logic        tx_clr = 1'b0;
    logic [1:0]  rdy_cnt;
    logic        rdy_stall = 1'b0;

    assign tx_data      = 8'((tx_idx * 13 + 5) & 8'hFF);
    assign tx_out_ready = !(rdy_stall && rdy_cnt == 2'd2);

    always @(posedge clk) begin
        if (tx_clr) tx_idx <= 0;
        else if (tx_data_rd) tx_idx <= tx_idx + 1;
        if (rdy_cnt == 2'd2) rdy_cnt <= 2'd0;
        else rdy_cnt <= rdy_cnt + 2'd1;
    end

    initial rdy_cnt = 2'd0;
    initial tx_idx = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid) begin cmd_seen++; got_code = cmd_code; got_len = cmd_len; end
            if (data_valid) begin
                if (data_cnt >= 64 || data_byte != exp_data[data_cnt]) data_bad++;
                data_cnt++;
            end
            if (pkt_done) begin done_seen++; got_ok = pkt_crc_ok; got_err = pkt_code_err; end
            if (pkt_abort) abort_seen++;
            if (tx_out_valid && tx_out_ready) begin
                if (tx_cnt >= 40 || tx_out_byte != exp_tx[tx_cnt]) tx_bad++;
                tx_cnt++;
            end
            if (tx_data_rd) rd_cnt++;
        end
    end

    function automatic logic [15:0] fcs(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = r[0] ^ b[k];
            r  = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    task automatic check(input bit cond, input string req, input int act, input int expv);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
        end
    endtask

    task automatic clear_sb();
        cmd_seen = 0; data_cnt = 0; data_bad = 0; done_seen = 0; abort_seen = 0;
        got_code = 8'h00; got_len = 16'h0; got_ok = 1'b0; got_err = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit with_tick);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; byte_tick = with_tick;
        @(negedge clk);
        rx_valid = 1'b0; byte_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); byte_tick = 1'b1;
            @(negedge clk); byte_tick = 1'b0;
        end
    endtask

    // mode: 0 good crc, 1 corrupted crc, 2 zero crc
    task automatic rx_packet(input logic [7:0] code, input int len, input int mode);
        logic [15:0] c, sent;
        int n;
        n = code[7] ? len : 0;
        clear_sb();
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) exp_data[i] = 8'((i * 29 + len * 7 + code) & 8'hFF);
        send_byte(8'h55, 1'b0);
        send_byte(code, 1'b0); c = fcs(c, code);
        if (code[7]) begin
            send_byte(8'(len >> 8), 1'b0); c = fcs(c, 8'(len >> 8));
            send_byte(8'(len), 1'b0);      c = fcs(c, 8'(len));
            for (int i = 0; i < n; i++) begin
                send_byte(exp_data[i], 1'b0); c = fcs(c, exp_data[i]);
            end
        end
        sent = (mode == 2) ? 16'h0000 : (mode == 1) ? (~c ^ 16'h8001) : ~c;
        send_byte(sent[7:0], 1'b0);
        send_byte(sent[15:8], 1'b0);
        @(negedge clk);
        check(cmd_seen == 1, "R2 cmd strobe count", cmd_seen, 1);
        check(got_code == code, "R2 cmd_code", got_code, code);
        check(got_len == 16'(n), "R3 cmd_len", got_len, n);
        check(data_cnt == n && data_bad == 0, "R3 data stream", data_cnt, n);
        check(done_seen == 1, "R4 pkt_done count", done_seen, 1);
        check(got_ok == ((sent == 16'h0) || (sent == ~c)),
              (mode == 2) ? "R5 zero crc accepted" : "R4 crc status",
              got_ok, (sent == 16'h0) || (sent == ~c));
        check(got_err == code[6], "R6 response flag error", got_err, code[6]);
    endtask

    task automatic tx_packet(input logic [7:0] code, input int len, input bit poke);
        logic [15:0] c;
        logic [7:0] cd;
        int n, k;
        n = code[7] ? len : 0;
        cd = code | 8'h40;
        c = 16'hFFFF;
        k = 0;
        exp_tx[k++] = 8'h55;
        exp_tx[k++] = cd; c = fcs(c, cd);
        if (code[7]) begin
            exp_tx[k++] = 8'(len >> 8); c = fcs(c, 8'(len >> 8));
            exp_tx[k++] = 8'(len);      c = fcs(c, 8'(len));
            for (int i = 0; i < n; i++) begin
                exp_tx[k] = 8'((i * 13 + 5) & 8'hFF); c = fcs(c, exp_tx[k]); k++;
            end
        end
        c = ~c;
        exp_tx[k++] = c[7:0];
        exp_tx[k++] = c[15:8];
        @(negedge clk);
        tx_clr = 1'b1;
        @(negedge clk);
        tx_clr = 1'b0; tx_cnt = 0; tx_bad = 0; rd_cnt = 0;
        tx_start = 1'b1; tx_code = code; tx_len = 16'(len);
        @(negedge clk);
        tx_start = 1'b0;
        if (poke) begin
            @(negedge clk);
            tx_start = 1'b1; tx_code = 8'h9F; tx_len = 16'd3;
            @(negedge clk);
            tx_start = 1'b0;
        end
        for (int w = 0; w < 200 && tx_busy; w++) @(negedge clk);
        @(negedge clk);
        check(tx_cnt == k, poke ? "R9 length with start while busy" : "R8 tx byte count", tx_cnt, k);
        check(tx_bad == 0, poke ? "R9 bytes with start while busy" : "R8 tx byte values", tx_bad, 0);
        check(rd_cnt == n, "R8 tx data pulls", rd_cnt, n);
        check(!tx_busy, "R8 tx returns idle", tx_busy, 0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        clear_sb();
        tx_cnt = 0; tx_bad = 0; rd_cnt = 0;
        repeat (3) @(negedge clk);
        // R11 reset state while held
        check(!cmd_valid && !data_valid && !pkt_done && !pkt_abort, "R11 strobes low in reset",
              {cmd_valid, data_valid, pkt_done, pkt_abort}, 0);
        check(!tx_out_valid && !tx_busy, "R11 tx idle in reset", {tx_out_valid, tx_busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!tx_busy, "R11 tx idle after reset", tx_busy, 0);

        // R1 junk while hunting, no events
        clear_sb();
        send_byte(8'h00, 1'b0); send_byte(8'hAA, 1'b0); send_byte(8'h81, 1'b0);
        send_byte(8'h54, 1'b0); send_byte(8'hD5, 1'b0);
        @(negedge clk);
        check(cmd_seen + data_cnt + done_seen + abort_seen == 0, "R1 junk ignored",
              cmd_seen + data_cnt + done_seen + abort_seen, 0);

        // R2..R6 sweep over every code value
        for (int code = 0; code < 256; code++) begin
            if (code % 16 == 3) begin
                clear_sb();
                send_byte(8'h13, 1'b0); send_byte(8'hFF, 1'b0);
                @(negedge clk);
                check(cmd_seen == 0, "R1 junk before sync", cmd_seen, 0);
            end
            rx_packet(8'(code), code % 7, code % 3);
        end

        // R7 idle timeout one below the limit, then at the limit
        clear_sb();
        send_byte(8'h55, 1'b0);
        send_byte(8'h81, 1'b0);
        ticks(LIM);
        @(negedge clk);
        check(abort_seen == 0, "R7 no abort at limit", abort_seen, 0);
        ticks(1);
        @(negedge clk);
        check(abort_seen == 1, "R7 abort past limit", abort_seen, 1);
        clear_sb();
        send_byte(8'h01, 1'b0); send_byte(8'h02, 1'b0); send_byte(8'h03, 1'b0);
        @(negedge clk);
        check(cmd_seen == 0 && done_seen == 0, "R7 back to hunting", cmd_seen + done_seen, 0);

        // R7 byte with tick restarts the count; packet completes
        begin
            logic [15:0] c;
            clear_sb();
            exp_data[0] = 8'h5A;
            c = 16'hFFFF;
            send_byte(8'h55, 1'b0);
            send_byte(8'h82, 1'b0); c = fcs(c, 8'h82);
            ticks(LIM);
            send_byte(8'h00, 1'b1); c = fcs(c, 8'h00);
            ticks(LIM);
            send_byte(8'h01, 1'b0); c = fcs(c, 8'h01);
            send_byte(8'h5A, 1'b0); c = fcs(c, 8'h5A);
            c = ~c;
            send_byte(c[7:0], 1'b0);
            send_byte(c[15:8], 1'b0);
            @(negedge clk);
            check(abort_seen == 0, "R7 byte restarts idle count", abort_seen, 0);
            check(done_seen == 1 && got_ok, "R7 packet survives idle gaps", done_seen, 1);
        end

        // R7 no abort while hunting
        clear_sb();
        ticks(LIM * 3);
        @(negedge clk);
        check(abort_seen == 0, "R7 no abort while hunting", abort_seen, 0);

        // R8 transmit sweep, ready always high then stalling
        for (int s = 0; s < 2; s++) begin
            rdy_stall = (s == 1);
            for (int l = 0; l < 6; l++) tx_packet(8'(8'h80 | l), l, 1'b0);
            tx_packet(8'h03, 7, 1'b0);
            tx_packet(8'h40, 0, 1'b0);
        end
        // R9 start while busy
        tx_packet(8'h85, 4, 1'b1);
        tx_packet(8'h11, 2, 1'b1);

        finish_up();
    end
endmodule